// File: doc/BRIEF.md
# Page Write Commit Engine

This block sits behind a serial memory bus controller and collects the data bytes of one write command into a page buffer. When the command closes cleanly, it commits the buffered bytes to the storage array during a self-timed busy period. The bus controller reports protocol events as single-cycle pulses: a start, the loaded word address, each sampled data bit, and a stop. Completed data bytes arrive over a valid/ready stream. A write-protect level and a low-supply lockout level can suppress the commit.

A byte moves across the stream in a cycle where `byte_valid` and `byte_ready` are both high. `byte_ready` is high only while a write command is collecting data. It is low in idle and for the whole busy period. A byte offered while ready is low is not taken. The controller is expected to hold it or to answer the bus with a not-acknowledge. During busy the engine drives one array write strobe for each page location that received data, then stays busy until a fixed cycle count has run out.

Top module: `page_commit_engine`

## Requirements
- R1: The word address splits into a page number (its bits above the low 4) and a 4-bit offset. Each accepted data byte goes to the current offset, and the offset then advances modulo 16 while the page number stays fixed. From offset 0Eh the order is 0Eh, 0Fh, 00h, 01h.
- R2: When more than 16 bytes are sent, each excess byte overwrites the buffered byte at its wrapped offset, so the last byte sent to an offset is the one committed.
- R3: A commit starts only on a stop that arrives while collecting, after at least one data byte, and with no data bits sampled since the last accepted byte. A stop that arrives mid-byte, or before any data byte, drops the command: there is no busy period and no array write.
- R4: A commit raises `busy` in the cycle after the stop. `busy` stays high for exactly BUSY_CYCLES cycles, whatever the number of bytes.
- R5: During the first PAGE_BYTES cycles of busy, `mem_we` pulses once for each offset that received a byte, in ascending offset order. `mem_addr` is {page, offset} and `mem_wdata` is the buffered byte. Offsets that received nothing get no strobe and keep their old contents.
- R6: A high level on `wp` is ignored from the start until the first data bit of the first data byte is sampled.
- R7: From the cycle that samples the first data bit up to the stop, a high level on `wp` cancels the command. The engine returns to idle, `byte_ready` drops, and nothing is written.
- R8: `low_vdd` high at the stop prevents the commit. `low_vdd` high during busy suppresses every array strobe in those cycles.
- R9: While busy, `byte_ready` is low and start, address, data-bit and stop events are ignored. A new command neither starts nor lengthens the busy period.
- R10: After reset, `busy`, `byte_ready` and `mem_we` are low.
- R11: A start while collecting discards every byte collected so far. Only bytes of a command that follows it can be committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | Start condition pulse |
| stop_evt | input | 1 | Stop condition pulse |
| addr_valid | input | 1 | Word address of a write command has been received |
| addr_in | input | ADDR_W | Word address (page number and offset) |
| data_bit | input | 1 | A data-byte bit was sampled on the bus |
| byte_valid | input | 1 | Stream: a completed data byte is offered |
| byte_ready | output | 1 | Stream: engine accepts a data byte |
| byte_data | input | DATA_W | Stream: data byte |
| wp | input | 1 | Write-protect level |
| low_vdd | input | 1 | Low-supply lockout level |
| busy | output | 1 | Commit in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |

## Verification
The bench builds the engine with a 16-byte page, a 7-bit address (eight pages) and BUSY_CYCLES of 24. With these values a full 128-byte array model can be compared after every command. The busy period is short enough for a sweep over every start offset, with byte counts of 1, 2, 16, 17 and 19, spread across all pages. This covers wrap-around, overwrite of excess bytes and partial pages. It also shows the fixed busy length both at its lower bound (one byte) and past a full page. Directed runs then place `wp`, `low_vdd`, stops and starts on each side of the first data bit, mid-byte, and inside the busy window.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BUSY    = 2'd2
  } eng_state_t;
endpackage

// File: rtl/pce_page_buffer.sv
module pce_page_buffer #(
  parameter int PAGE_BYTES = 16,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_mask
);
  logic [DATA_W-1:0]     store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask <= '0;
    else if (clr) mask <= '0;
    else if (wr_en) mask[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) store[wr_idx] <= wr_data;
  end

  assign rd_data = store[rd_idx];
  assign rd_mask = mask[rd_idx];

  // R5: a received byte is remembered for the commit
  assert_mask_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> mask[$past(wr_idx)]);
endmodule

// File: rtl/pce_busy_timer.sv
module pce_busy_timer #(
  parameter int BUSY_CYCLES = 500000,
  parameter int PAGE_BYTES  = 16,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  output logic             active,
  output logic             done,
  output logic             scan_on,
  output logic [IDX_W-1:0] scan_idx
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (go) begin
        active <= 1'b1;
        cnt    <= '0;
      end
    end else if (done) begin
      active <= 1'b0;
      cnt    <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign done     = active && (cnt == CNT_W'(BUSY_CYCLES - 1));
  assign scan_on  = active && (cnt < CNT_W'(PAGE_BYTES));
  assign scan_idx = cnt[IDX_W-1:0];

  // R4: every busy period counts from zero
  assert_timer_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> (cnt == '0));
endmodule

// File: rtl/pce_cmd_tracker.sv
module pce_cmd_tracker
  import pce_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int PAGE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_bit,
  input  logic              byte_fire,
  input  logic              wp,
  input  logic              low_vdd,
  input  logic              timer_done,
  output logic              collecting,
  output logic              in_busy,
  output logic [PAGE_W-1:0] page,
  output logic [IDX_W-1:0]  ofs,
  output logic              buf_clr,
  output logic              buf_wr,
  output logic              go
);
  eng_state_t state, state_nx;
  logic armed, partial, have_byte;
  logic cancel, commit_ok;

  assign collecting = (state == ST_COLLECT);
  assign in_busy    = (state == ST_BUSY);
  assign cancel     = collecting && !start_evt && wp && (armed || data_bit);
  assign commit_ok  = collecting && !start_evt && !cancel && stop_evt &&
                      have_byte && !partial && !low_vdd;
  assign buf_wr     = collecting && byte_fire && !start_evt && !cancel && !stop_evt;
  assign go         = commit_ok;

  always_comb begin
    state_nx = state;
    buf_clr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start_evt) buf_clr = 1'b1;
        else if (addr_valid) begin
          state_nx = ST_COLLECT;
          buf_clr  = 1'b1;
        end
      end
      ST_COLLECT: begin
        if (start_evt || cancel || (stop_evt && !commit_ok)) begin
          state_nx = ST_IDLE;
          buf_clr  = 1'b1;
        end else if (commit_ok) state_nx = ST_BUSY;
      end
      ST_BUSY: begin
        if (timer_done) begin
          state_nx = ST_IDLE;
          buf_clr  = 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      armed     <= 1'b0;
      partial   <= 1'b0;
      have_byte <= 1'b0;
      page      <= '0;
      ofs       <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && !start_evt && addr_valid) begin
        page      <= addr_in[ADDR_W-1:IDX_W];
        ofs       <= addr_in[IDX_W-1:0];
        armed     <= 1'b0;
        partial   <= 1'b0;
        have_byte <= 1'b0;
      end else if (collecting) begin
        if (data_bit) begin
          armed   <= 1'b1;
          partial <= 1'b1;
        end
        if (buf_wr) begin
          partial   <= 1'b0;
          have_byte <= 1'b1;
          ofs       <= ofs + 1'b1;
        end
      end
    end
  end

  // R7: an armed write-protect level ends the command
  assert_wp_cancel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && armed && wp && !start_evt) |=> (state == ST_IDLE));
  // R9: busy holds until the timer has run out
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_busy && !timer_done) |=> in_busy);
  // R3: a stop mid-byte never leads to a commit
  assert_partial_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (collecting && stop_evt && partial) |=> !in_busy);
endmodule

// File: rtl/page_commit_engine.sv
module page_commit_engine #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_BYTES  = 16,
  parameter int BUSY_CYCLES = 500000,
  localparam int IDX_W      = $clog2(PAGE_BYTES),
  localparam int PAGE_W     = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic              addr_valid,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_bit,
  input  logic              byte_valid,
  output logic              byte_ready,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              wp,
  input  logic              low_vdd,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  logic              collecting, in_busy, buf_clr, buf_wr, go;
  logic              t_active, t_done, scan_on, rd_mask;
  logic [PAGE_W-1:0] page;
  logic [IDX_W-1:0]  ofs, scan_idx;
  logic [DATA_W-1:0] rd_data;

  assign byte_ready = collecting;

  pce_cmd_tracker #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_trk (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_valid(addr_valid), .addr_in(addr_in), .data_bit(data_bit),
    .byte_fire(byte_valid && byte_ready), .wp(wp), .low_vdd(low_vdd),
    .timer_done(t_done), .collecting(collecting), .in_busy(in_busy),
    .page(page), .ofs(ofs), .buf_clr(buf_clr), .buf_wr(buf_wr), .go(go)
  );

  pce_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr), .wr_idx(ofs),
    .wr_data(byte_data), .rd_idx(scan_idx), .rd_data(rd_data), .rd_mask(rd_mask)
  );

  pce_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES), .PAGE_BYTES(PAGE_BYTES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .go(go), .active(t_active), .done(t_done),
    .scan_on(scan_on), .scan_idx(scan_idx)
  );

  assign busy      = in_busy;
  assign mem_we    = scan_on && rd_mask && !low_vdd;
  assign mem_addr  = {page, scan_idx};
  assign mem_wdata = rd_data;

  // R5: strobes only inside a commit
  assert_we_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R8: no array write under supply lockout
  assert_we_lowvdd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !low_vdd);
  // R9: the stream is closed while busy
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> !busy);
  // R4: controller state and timer agree on the busy window
  assert_busy_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy == t_active);
endmodule

// File: tb/page_commit_engine_tb.sv
module page_commit_engine_tb;
  localparam int AW = 7, DW = 8, PB = 16, BUSY = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_evt = 0, stop_evt = 0, addr_valid = 0, data_bit = 0;
  logic byte_valid = 0, wp = 0, low_vdd = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] byte_data = '0;
  logic byte_ready, busy, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  int total = 0, bad = 0, busy_cnt = 0;
  bit order_bad = 0, seen_we = 0, done_flag = 0;
  logic [AW-1:0] last_a;
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] expv[2**AW];

  always #5 clk = ~clk;

  page_commit_engine #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .addr_valid(addr_valid), .addr_in(addr_in), .data_bit(data_bit),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .wp(wp), .low_vdd(low_vdd), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (mem_we) begin
        mem[mem_addr] = mem_wdata;
        if (seen_we && mem_addr <= last_a) order_bad = 1;
        seen_we = 1;
        last_a = mem_addr;
      end
      if (!busy) seen_we = 0;
    end
  end

  task automatic check(input string req, input int act, input int expd);
    total++;
    if (act != expd) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expd);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic do_start(); start_evt = 1; tick(); start_evt = 0; endtask
  task automatic do_stop();  stop_evt = 1;  tick(); stop_evt = 0;  endtask
  task automatic do_addr(input logic [AW-1:0] a);
    addr_valid = 1; addr_in = a; tick(); addr_valid = 0;
  endtask
  task automatic do_bits(input int n);
    for (int i = 0; i < n; i++) begin data_bit = 1; tick(); data_bit = 0; end
  endtask
  task automatic do_byte(input logic [DW-1:0] d);
    do_bits(8);
    byte_valid = 1; byte_data = d; tick(); byte_valid = 0;
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int b, input int k);
    return DW'(a * 7 + b * 13 + k * 29 + 1);
  endfunction

  task automatic mem_check(input string req);
    int diff = 0;
    for (int i = 0; i < 2**AW; i++) if (mem[i] !== expv[i]) diff++;
    check(req, diff, 0);
  endtask

  // stop then wait out the busy window and verify
  task automatic finish_cmd(input bit commit, input string req);
    busy_cnt = 0; order_bad = 0;
    do_stop();
    repeat (BUSY + 6) tick();
    check({req, " busy length R4"}, busy_cnt, commit ? BUSY : 0);
    check({req, " strobe order R5"}, int'(order_bad), 0);
    mem_check({req, " array contents"});
  endtask

  task automatic write_cmd(input int pg, input int so, input int n, input bit commit, input string req);
    do_start();
    do_addr(AW'(pg * PB + so));
    for (int k = 0; k < n; k++) begin
      do_byte(pat(so, n, k));
      if (commit) expv[pg * PB + ((so + k) % PB)] = pat(so, n, k);
    end
    finish_cmd(commit, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done_flag) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lens[5] = '{1, 2, 16, 17, 19};
    for (int i = 0; i < 2**AW; i++) begin mem[i] = 8'hFF; expv[i] = 8'hFF; end
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    check("R10 busy", busy, 0);
    check("R10 ready", byte_ready, 0);
    check("R10 we", mem_we, 0);

    // R1 R2 R4 R5 sweep of start offset and byte count
    for (int so = 0; so < PB; so++)
      for (int li = 0; li < 5; li++)
        write_cmd((so + li) % 8, so, lens[li], 1, "R1 R2 sweep");

    // R3 stop mid-byte
    do_start(); do_addr(AW'(3 * PB + 5)); do_byte(8'h11); do_bits(3);
    finish_cmd(0, "R3 mid-byte stop");
    // R3 stop with no data byte
    do_start(); do_addr(AW'(3 * PB + 5));
    finish_cmd(0, "R3 no data");

    // R6 wp high before first data bit is ignored
    wp = 1; do_start(); do_addr(AW'(5 * PB + 2)); wp = 0;
    do_byte(8'hA5); expv[5 * PB + 2] = 8'hA5;
    finish_cmd(1, "R6 early wp");

    // R7 wp high mid second byte cancels
    do_start(); do_addr(AW'(6 * PB + 9)); do_byte(8'h3C); do_bits(4);
    wp = 1; tick(); wp = 0;
    @(negedge clk); check("R7 ready after cancel", byte_ready, 0);
    tick();
    finish_cmd(0, "R7 wp cancel");
    // R7 wp high at first data bit cancels
    do_start(); do_addr(AW'(6 * PB + 1));
    wp = 1; do_byte(8'h77); wp = 0;
    finish_cmd(0, "R7 wp at first bit");

    // R8 low supply at stop
    do_start(); do_addr(AW'(2 * PB)); do_byte(8'h5A);
    low_vdd = 1; finish_cmd(0, "R8 lockout at stop"); low_vdd = 0;
    // R8 low supply during busy
    do_start(); do_addr(AW'(2 * PB + 4)); do_byte(8'h66); do_byte(8'h67);
    busy_cnt = 0;
    do_stop(); low_vdd = 1;
    repeat (BUSY + 6) tick();
    low_vdd = 0;
    check("R8 busy still runs R4", busy_cnt, BUSY);
    mem_check("R8 lockout in busy");

    // R9 command during busy is ignored
    do_start(); do_addr(AW'(7 * PB + 14)); do_byte(8'hC1); do_byte(8'hC2);
    expv[7 * PB + 14] = 8'hC1; expv[7 * PB + 15] = 8'hC2;
    busy_cnt = 0; order_bad = 0;
    do_stop();
    do_start(); do_addr(AW'(4 * PB)); byte_valid = 1; byte_data = 8'hEE;
    @(negedge clk); check("R9 ready low in busy", byte_ready, 0);
    tick(); byte_valid = 0;
    do_stop();
    repeat (BUSY + 6) tick();
    check("R9 busy not extended", busy_cnt, BUSY);
    mem_check("R9 ignored command");

    // R11 restart discards collected bytes
    do_start(); do_addr(AW'(1 * PB + 3)); do_byte(8'h90); do_byte(8'h91);
    do_start(); do_addr(AW'(1 * PB + 8)); do_byte(8'h92);
    expv[1 * PB + 8] = 8'h92;
    finish_cmd(1, "R11 restart");

    done_flag = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule